// File: doc/BRIEF.md
# Card Socket I/O Window Decoder

This block decides whether a system I/O port access belongs to a card socket. It holds two programmable port ranges. Each range has an inclusive 16-bit lower and upper bound and its own enable. For every access presented on the decode side, the block reports three things one clock later: whether any enabled range contains the port address, which range won, and the access attributes that apply. Those attributes are the data width, zero-wait-state operation and the timing set.

Software programs the block through a byte-wide indexed register port: an index selects a register, and a write strobe stores the data byte there. The same index returns the stored byte on the read data output one clock later. A single control byte carries one four-bit attribute group per range. The data width can be fixed at 16 bits, fixed at 8 bits, or left to the card, which then signals a 16-bit access on a dedicated input during the access.

Top module: `io_window_decoder`

## Requirements
- R1: After a synchronous reset every register reads back as 0x00, and `hit_o`, `win_o`, `wide_o`, `zero_ws_o` and `timing_o` are all 0.
- R2: A write to an index in the range 0x06..0x0F stores the data byte unchanged. `rdata_o` shows the byte stored at `idx_i` one clock after the index is presented.
- R3: Writes to indices outside 0x06..0x0F change no register, and reads of those indices return 0x00.
- R4: A range matches an access only when lower ≤ address ≤ upper, and both bounds are inclusive.
- R5: In the enable register at index 0x06, bit 6 enables range 0 and bit 7 enables range 1. A disabled range never matches. Bits 0..5 of that register have no effect on decoding.
- R6: When both ranges match, `win_o` is 0 (range 0 wins).
- R7: A range whose lower bound is above its upper bound matches no address.
- R8: The bounds are built from bytes. Range 0 uses lower-low 0x08, lower-high 0x09, upper-low 0x0A and upper-high 0x0B. Range 1 uses 0x0C..0x0F in the same order.
- R9: The control register sits at index 0x07. Range 0 uses bits 0..3 and range 1 uses bits 4..7, with the same layout in each group: +0 forces 16-bit width, +1 lets the card decide the width, +2 selects zero wait states, +3 selects timing set 1. `zero_ws_o` and `timing_o` copy the winning range's bits.
- R10: `wide_o` is 1 when the winning range forces 16-bit width. Otherwise, when the card decides, `wide_o` follows `card_wide_i` sampled with the access. Otherwise it is 0.
- R11: Decode results appear one clock after the access is presented. With `acc_valid_i` low, or on a miss, `hit_o` is 0 and `win_o`, `wide_o`, `zero_ws_o` and `timing_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| idx_i | input | 6 | Register index |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Registered read data for `idx_i` |
| acc_valid_i | input | 1 | An I/O access is presented |
| acc_addr_i | input | 16 | I/O port address of the access |
| card_wide_i | input | 1 | Card requests a 16-bit transfer |
| hit_o | output | 1 | An enabled range contains the address |
| win_o | output | 1 | Index of the winning range |
| wide_o | output | 1 | Effective width is 16 bits |
| zero_ws_o | output | 1 | Zero wait states apply |
| timing_o | output | 1 | Timing set 1 applies |

## Verification
A corrupted bound byte or enable bit shows up as a wrong hit or a wrong range index one clock after the first access that lands on an edge of the affected range. This is why the stimulus aims most addresses at lower−1, lower, upper and upper+1. Swapped or shifted attribute nibbles show up as wrong width or timing outputs on the first hit in the affected range. A stuck register byte shows up on the readback port one clock after that index is read. Overlapping ranges with different attributes expose a wrong priority order at once.

// File: rtl/iowin_pkg.sv
package iowin_pkg;

  localparam int NUM_WIN    = 2;
  localparam int WIN_W      = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
  localparam int ENA_IDX    = 6;
  localparam int CTRL_IDX   = 7;
  localparam int WIN_BASE   = 8;
  localparam int WIN_STRIDE = 4;
  localparam int ENA_BIT0   = 6;
  localparam int LAST_IDX   = WIN_BASE + NUM_WIN * WIN_STRIDE - 1;
  localparam int NUM_REGS   = LAST_IDX - ENA_IDX + 1;

  // attribute group of one range, bit 0 is the least significant field
  typedef struct packed {
    logic timing;
    logic zero_ws;
    logic card_ovr;
    logic wide16;
  } io_attr_t;

endpackage

// File: rtl/iowin_regfile.sv
module iowin_regfile
  import iowin_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en_i,
  input  logic [IDX_W-1:0]                 idx_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [DATA_W-1:0]                rdata_o,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]   lo_o,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]   hi_o,
  output logic [NUM_WIN-1:0]               en_o,
  output io_attr_t [NUM_WIN-1:0]           attr_o
);

  localparam int OFF_W = $clog2(NUM_REGS);

  logic [DATA_W-1:0] regs [NUM_REGS];
  logic              in_range;
  logic [IDX_W-1:0]  off_full;
  logic [OFF_W-1:0]  off;

  always_comb begin
    in_range = (idx_i >= IDX_W'(ENA_IDX)) && (idx_i <= IDX_W'(LAST_IDX));
    off_full = idx_i - IDX_W'(ENA_IDX);
    off      = off_full[OFF_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (wr_en_i && in_range) begin
      regs[off] <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           rdata_o <= '0;
    else if (in_range) rdata_o <= regs[off];
    else               rdata_o <= '0;
  end

  localparam int ENA_OFF  = 0;
  localparam int CTRL_OFF = CTRL_IDX - ENA_IDX;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam int B = WIN_BASE - ENA_IDX + w * WIN_STRIDE;
    assign lo_o[w]   = {regs[B+1], regs[B]};
    assign hi_o[w]   = {regs[B+3], regs[B+2]};
    assign en_o[w]   = regs[ENA_OFF][ENA_BIT0 + w];
    assign attr_o[w] = io_attr_t'(regs[CTRL_OFF][4*w +: 4]);
  end

endmodule

// File: rtl/iowin_match.sv
module iowin_match
  import iowin_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                           acc_valid_i,
  input  logic [ADDR_W-1:0]              acc_addr_i,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0] lo_i,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0] hi_i,
  input  logic [NUM_WIN-1:0]             en_i,
  output logic [NUM_WIN-1:0]             match_o
);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    logic above_lo, below_hi;
    assign above_lo   = acc_addr_i >= lo_i[w];
    assign below_hi   = acc_addr_i <= hi_i[w];
    assign match_o[w] = acc_valid_i && en_i[w] && above_lo && below_hi;
  end

endmodule

// File: rtl/iowin_select.sv
module iowin_select
  import iowin_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_WIN-1:0]     match_i,
  input  io_attr_t [NUM_WIN-1:0] attr_i,
  input  logic                   card_wide_i,
  output logic                   hit_o,
  output logic [WIN_W-1:0]       win_o,
  output logic                   wide_o,
  output logic                   zero_ws_o,
  output logic                   timing_o
);

  logic             found;
  logic [WIN_W-1:0] sel;
  io_attr_t         a;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (match_i[w]) begin
        found = 1'b1;
        sel   = WIN_W'(w);
      end
    end
    a = attr_i[sel];
  end

  always_ff @(posedge clk) begin
    if (rst || !found) begin
      hit_o     <= 1'b0;
      win_o     <= '0;
      wide_o    <= 1'b0;
      zero_ws_o <= 1'b0;
      timing_o  <= 1'b0;
    end else begin
      hit_o     <= 1'b1;
      win_o     <= sel;
      wide_o    <= a.wide16 | (a.card_ovr & card_wide_i);
      zero_ws_o <= a.zero_ws;
      timing_o  <= a.timing;
    end
  end

  // R6: a later range only wins when range 0 did not match
  assert_low_index_first_R6: assert property (@(posedge clk) disable iff (rst)
    (hit_o && win_o != '0) |-> $past(!match_i[0]));

  // R11: a miss leaves every attribute output low
  assert_miss_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !hit_o |-> (!wide_o && !zero_ws_o && !timing_o && win_o == '0));

endmodule

// File: rtl/io_window_decoder.sv
module io_window_decoder
  import iowin_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              card_wide_i,
  output logic              hit_o,
  output logic [WIN_W-1:0]  win_o,
  output logic              wide_o,
  output logic              zero_ws_o,
  output logic              timing_o
);

  logic [NUM_WIN-1:0][ADDR_W-1:0] lo, hi;
  logic [NUM_WIN-1:0]             en;
  io_attr_t [NUM_WIN-1:0]         attr;
  logic [NUM_WIN-1:0]             match;

  iowin_regfile #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .idx_i(idx_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .lo_o(lo), .hi_o(hi), .en_o(en), .attr_o(attr)
  );

  iowin_match #(.ADDR_W(ADDR_W)) u_match (
    .acc_valid_i(acc_valid_i), .acc_addr_i(acc_addr_i),
    .lo_i(lo), .hi_i(hi), .en_i(en), .match_o(match)
  );

  iowin_select u_sel (
    .clk(clk), .rst(rst), .match_i(match), .attr_i(attr), .card_wide_i(card_wide_i),
    .hit_o(hit_o), .win_o(win_o), .wide_o(wide_o), .zero_ws_o(zero_ws_o),
    .timing_o(timing_o)
  );

  // R11: a hit only follows a presented access
  assert_hit_needs_access_R11: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> $past(acc_valid_i));

  // R4: a range-0 hit lies inside the enabled inclusive bounds
  assert_inside_bounds_R4: assert property (@(posedge clk) disable iff (rst)
    (hit_o && win_o == '0) |->
      $past(en[0] && (acc_addr_i >= lo[0]) && (acc_addr_i <= hi[0])));

  // R10: a wide range-0 access is forced or requested by the card
  assert_width_source_R10: assert property (@(posedge clk) disable iff (rst)
    (hit_o && win_o == '0 && wide_o) |->
      $past(attr[0].wide16 || (attr[0].card_ovr && card_wide_i)));

endmodule

// File: tb/io_window_decoder_tb_top.sv
module io_window_decoder_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [5:0] idx = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       acc_valid = 1'b0;
  logic [15:0] acc_addr = '0;
  logic       card_wide = 1'b0;
  logic       hit, win, wide, zws, tim;

  int checks = 0;
  int fails  = 0;
  logic [7:0] m [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  io_window_decoder dut_i (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .idx_i(idx), .wdata_i(wdata),
    .rdata_o(rdata), .acc_valid_i(acc_valid), .acc_addr_i(acc_addr),
    .card_wide_i(card_wide), .hit_o(hit), .win_o(win), .wide_o(wide),
    .zero_ws_o(zws), .timing_o(tim)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lo_of(input int w);
    return {m[9+4*w], m[8+4*w]};
  endfunction
  function automatic logic [15:0] hi_of(input int w);
    return {m[11+4*w], m[10+4*w]};
  endfunction
  function automatic bit in_win(input int w, input logic [15:0] a);
    return m[6][6+w] && a >= lo_of(w) && a <= hi_of(w);
  endfunction
  // expected {hit, win, wide, zero_ws, timing}
  function automatic logic [7:0] expect_out(input logic v, input logic [15:0] a, input logic cw);
    logic [3:0] nib;
    int w;
    if (!v) return 8'h00;
    if (in_win(0, a)) w = 0;
    else if (in_win(1, a)) w = 1;
    else return 8'h00;
    nib = m[7][4*w +: 4];
    return {3'b000, 1'b1, 1'(w), nib[0] | (nib[1] & cw), nib[2], nib[3]};
  endfunction

  task automatic wr(input logic [5:0] i, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; idx = i; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (i >= 6 && i <= 15) m[i] = d;
  endtask

  task automatic rd(input logic [5:0] i, input string req);
    @(negedge clk);
    idx = i;
    @(negedge clk);
    check(req, rdata, (i >= 6 && i <= 15) ? m[i] : 8'h00);
  endtask

  task automatic acc(input logic v, input logic [15:0] a, input logic cw, input string req);
    @(negedge clk);
    acc_valid = v; acc_addr = a; card_wide = cw;
    @(negedge clk);
    check(req, {3'b000, hit, win, wide, zws, tim}, expect_out(v, a, cw));
    acc_valid = 1'b0;
  endtask

  task automatic set_win(input int w, input logic [15:0] lo, input logic [15:0] hi);
    wr(6'(8+4*w), lo[7:0]);  wr(6'(9+4*w), lo[15:8]);
    wr(6'(10+4*w), hi[7:0]); wr(6'(11+4*w), hi[15:8]);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 64; i++) m[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 outputs after reset", {3'b000, hit, win, wide, zws, tim}, 8'h00);
    for (int i = 6; i < 16; i++) rd(6'(i), "R1 register reset value");

    // R2/R8 programming and readback
    set_win(0, 16'h0300, 16'h031F);
    set_win(1, 16'h0310, 16'h0400);
    wr(6'd7, 8'hE1);          // range0: force 16; range1: card, zws, timing
    wr(6'd6, 8'hC0);
    for (int i = 6; i < 16; i++) rd(6'(i), "R2 readback");

    // R3 unmapped indices
    wr(6'd5, 8'hFF); wr(6'd16, 8'hAA); wr(6'd63, 8'h55);
    rd(6'd5, "R3 unmapped read"); rd(6'd16, "R3 unmapped read"); rd(6'd63, "R3 unmapped read");
    for (int i = 6; i < 16; i++) rd(6'(i), "R3 mapped unchanged");

    // R4/R6/R8/R9/R10 directed
    acc(1, 16'h02FF, 0, "R4 below lower");
    acc(1, 16'h0300, 0, "R4 at lower");
    acc(1, 16'h031F, 0, "R6 overlap goes to range 0");
    acc(1, 16'h0310, 1, "R6 overlap lower of range 1");
    acc(1, 16'h0320, 0, "R10 card narrow");
    acc(1, 16'h0320, 1, "R10 card wide");
    acc(1, 16'h0400, 1, "R4 at upper R9 attrs");
    acc(1, 16'h0401, 1, "R4 above upper");
    acc(0, 16'h0300, 1, "R11 valid low");

    // R5 enables
    wr(6'd6, 8'h80);
    acc(1, 16'h0310, 0, "R5 range 0 disabled");
    acc(1, 16'h0305, 1, "R5 range 0 disabled");
    wr(6'd6, 8'h3F);
    acc(1, 16'h0310, 1, "R5 low bits no effect");
    acc(1, 16'h0300, 1, "R5 low bits no effect");
    wr(6'd6, 8'hC0);

    // R7 empty range
    set_win(1, 16'h5000, 16'h4FFF);
    acc(1, 16'h5000, 0, "R7 inverted range");
    acc(1, 16'h4FFF, 1, "R7 inverted range");
    wr(6'd7, 8'h1A);          // range0: card, timing; range1: force 16
    set_win(1, 16'h0000, 16'hFFFF);
    acc(1, 16'h0000, 1, "R9 R10 full range 1");
    acc(1, 16'h0308, 1, "R9 R10 card wide range 0");
    acc(1, 16'h0308, 0, "R9 R10 card narrow range 0");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int r = $urandom_range(0, 15);
      if (r == 0) begin
        wr(6'($urandom_range(6, 15)), 8'($urandom()));
      end else if (r == 1) begin
        logic [5:0] ui = 6'($urandom_range(16, 63));
        wr(ui, 8'($urandom()));
        rd(ui, "R3 random unmapped");
      end else if (r == 2) begin
        rd(6'($urandom_range(6, 15)), "R2 random readback");
      end else begin
        int w = $urandom_range(0, 1);
        logic [15:0] a;
        case ($urandom_range(0, 4))
          0: a = lo_of(w) - 16'd1;
          1: a = lo_of(w);
          2: a = hi_of(w);
          3: a = hi_of(w) + 16'd1;
          default: a = 16'($urandom());
        endcase
        acc($urandom_range(0, 7) != 0, a, 1'($urandom()), "R4 R6 R10 R11 random access");
      end
    end
    finish_run();
  end

endmodule